// File: doc/BRIEF.md
# FM Bit-Clock Recovery Loop

This block recovers bit timing from an FM-encoded serial line. It runs from a sampling clock at 32 times the bit rate, and a 5-bit phase counter makes one full pass for each bit cell. Every FM cell has a transition at its boundary. The loop watches for that transition in a window around mid-count and moves its counter one step earlier or later to follow it. Transitions outside the window are ignored, including the data transitions in the middle of a cell. From the counter it derives a receive clock and a transmit clock, offset from each other by a quarter cell.

When a cell ends with no transition in the window, a sticky "one missed" flag is set and nothing else happens. If the next cell also ends with no transition, a sticky "two missed" flag is set and the loop drops into search mode. It does this at the count where both clocks are already low, so neither output ever produces a short pulse. In search mode both clocks stay low. The next transition on the line realigns the counter to the cell boundary, and the clocks start again from there.

The flags are cleared by a clear command, by a search command, or by disabling the loop. In NRZI mode the flags are held clear and missed transitions have no effect. The counter and both clocks still run in that mode.

Top module: `fm_dpll_recover`

## Requirements
- R1: After reset, and for as long as `enable` is low, `rclk`, `tclk`, `miss_one` and `miss_two` are 0 and the loop is in search mode. After `enable` rises, both clocks stay low until the first line transition.
- R2: The line input passes through a two-flop synchronizer. A transition arriving in search mode loads the counter with 17 (the value just past the cell boundary, 16). `rclk` goes high at the third rising sampling-clock edge after the transition, and not before.
- R3: While locked, `rclk` is high for counts 16 to 31 and `tclk` is high for counts 8 to 23. `tclk` rises 8 cycles before each `rclk` rise. With a transition every 32 cycles, `rclk` has a 32-cycle period and stays high for 16 cycles.
- R4: A transition seen at counts 12 to 15 makes the counter skip one count, so that cell lasts 31 cycles. One seen at counts 17 to 19 makes the counter repeat a count, so that cell lasts 33 cycles. One seen at count 16 leaves the cell at 32 cycles.
- R5: Transitions seen at counts 0 to 11 or 20 to 31 have no effect. A mid-cell data transition, which lands at count 0, leaves the `rclk` period at 32.
- R6: A cell that passes from count 31 to 0 with no transition at counts 12 to 19 sets `miss_one`. Nothing else changes: `miss_two` stays 0 and the clocks keep their 32-cycle period.
- R7: A second such cell directly after the first sets `miss_two`, exactly 32 cycles after `miss_one` rose. `miss_one` stays set, and search mode is requested.
- R8: A requested search begins at the step out of count 2, where both clocks are low. From then on `rclk` and `tclk` stay low, with no pulse, until the next transition.
- R9: Both flags are sticky. They are cleared on the next edge by `cmd_clr_miss`, by `cmd_search` or by `enable` low. `cmd_search` also puts the loop into search mode at once, so both clocks go low.
- R10: With `nrzi_mode` high, both flags are held at 0, missing transitions never cause a search, and the clocks keep running.
- R11: Leaving search mode restarts the clocks with the same timing as R2 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 32 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Loop enable; low holds the loop in search mode and clears the flags |
| nrzi_mode | input | 1 | 1 selects NRZI (flags held clear), 0 selects FM |
| serial_in | input | 1 | Encoded serial line, asynchronous to `clk` |
| cmd_search | input | 1 | One-cycle command: enter search mode and clear the flags |
| cmd_clr_miss | input | 1 | One-cycle command: clear both missed-transition flags |
| rclk | output | 1 | Recovered receive clock |
| tclk | output | 1 | Recovered transmit clock, a quarter cell ahead of `rclk` |
| miss_one | output | 1 | Sticky flag: a cell ended without a boundary transition |
| miss_two | output | 1 | Sticky flag: two cells in a row ended without one |

## Verification
The properties assume that the two commands and the mode inputs are synchronous to the sampling clock and that each command is a single-cycle pulse. They also assume that line transitions are spaced far enough apart for the synchronizer to turn each one into a single edge pulse. The bench meets these assumptions by changing every input only on the falling clock edge, by asserting each command for exactly one cycle, and by spacing line transitions at least 15 cycles apart. Cell lengths of 31, 32 and 33 cycles keep every boundary transition inside the tracking window, except where a transition is deliberately left out.

// File: rtl/fm_dpll_pkg.sv
package fm_dpll_pkg;

  // Phase correction chosen for the current sampling cycle
  typedef enum logic [1:0] {
    PH_STEP    = 2'd0,  // normal +1
    PH_ADVANCE = 2'd1,  // early edge: +2, cell one count shorter
    PH_HOLD    = 2'd2   // late edge: +0, cell one count longer
  } ph_corr_e;

  // Sticky missed-transition status
  typedef struct packed {
    logic two;
    logic one;
  } miss_bits_t;

endpackage

// File: rtl/fm_dpll_sync.sv
module fm_dpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_p
);
  localparam int LAST = STAGES;

  // chain[0..STAGES-1] synchronize, chain[STAGES] is the previous sample
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], din};
  end

  assign edge_p = chain[LAST] ^ chain[LAST-1];

endmodule

// File: rtl/fm_dpll_phase.sv
module fm_dpll_phase
  import fm_dpll_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int SEARCH_AT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             edge_p,
  input  logic             cmd_search,
  input  logic             search_req,
  output logic [CNT_W-1:0] cnt,
  output logic             searching,
  output logic             wrap,
  output logic             win_edge,
  output logic             relock,
  output logic             rclk,
  output logic             tclk
);
  localparam int CELL   = 1 << CNT_W;
  localparam int HALF   = CELL / 2;
  localparam int EIGHTH = CELL / 8;
  localparam int QTR    = CELL / 4;

  localparam logic [CNT_W-1:0] MAX_C    = CNT_W'(CELL - 1);
  localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] WIN_LO_C = CNT_W'(HALF - EIGHTH);
  localparam logic [CNT_W-1:0] WIN_HI_C = CNT_W'(HALF + EIGHTH - 1);
  localparam logic [CNT_W-1:0] TX_LO_C  = CNT_W'(QTR);
  localparam logic [CNT_W-1:0] TX_HI_C  = CNT_W'(HALF + QTR - 1);
  localparam logic [CNT_W-1:0] LOCK_C   = CNT_W'(HALF + 1);
  localparam logic [CNT_W-1:0] SRCH_C   = CNT_W'(SEARCH_AT);
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_C    = CNT_W'(2);

  logic             locked;
  logic             in_win;
  ph_corr_e         corr;
  logic [CNT_W-1:0] cnt_nxt;
  logic             srch_nxt;
  logic             rclk_nxt;
  logic             tclk_nxt;

  assign locked   = enable && !searching && !cmd_search;
  assign in_win   = (cnt >= WIN_LO_C) && (cnt <= WIN_HI_C);
  assign wrap     = locked && (cnt == MAX_C);
  assign win_edge = locked && edge_p && in_win;
  assign relock   = enable && !cmd_search && searching && edge_p;

  // classify the edge against the ideal boundary count
  always_comb begin
    corr = PH_STEP;
    if (win_edge) begin
      if (cnt < HALF_C)      corr = PH_ADVANCE;
      else if (cnt > HALF_C) corr = PH_HOLD;
    end
  end

  always_comb begin
    cnt_nxt  = cnt;
    srch_nxt = searching;
    if (!enable || cmd_search) begin
      cnt_nxt  = '0;
      srch_nxt = 1'b1;
    end else if (searching) begin
      if (edge_p) begin
        cnt_nxt  = LOCK_C;
        srch_nxt = 1'b0;
      end
    end else if (search_req && (cnt == SRCH_C)) begin
      cnt_nxt  = '0;
      srch_nxt = 1'b1;
    end else begin
      unique case (corr)
        PH_ADVANCE: cnt_nxt = cnt + TWO_C;
        PH_HOLD:    cnt_nxt = cnt;
        default:    cnt_nxt = cnt + ONE_C;
      endcase
    end
  end

  // outputs decoded from next state so they change only with the state
  always_comb begin
    rclk_nxt = !srch_nxt && (cnt_nxt >= HALF_C);
    tclk_nxt = !srch_nxt && (cnt_nxt >= TX_LO_C) && (cnt_nxt <= TX_HI_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      searching <= 1'b1;
      rclk      <= 1'b0;
      tclk      <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      searching <= srch_nxt;
      rclk      <= rclk_nxt;
      tclk      <= tclk_nxt;
    end
  end

endmodule

// File: rtl/fm_dpll_miss.sv
module fm_dpll_miss
  import fm_dpll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic nrzi_mode,
  input  logic cmd_search,
  input  logic cmd_clr,
  input  logic searching,
  input  logic wrap,
  input  logic win_edge,
  input  logic relock,
  output logic miss_one,
  output logic miss_two,
  output logic search_req
);
  miss_bits_t st;
  logic       seen;   // boundary edge found in this cell
  logic       prev;   // previous cell was a miss
  logic       pend;   // search entry scheduled

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      seen <= 1'b0;
      prev <= 1'b0;
      pend <= 1'b0;
    end else if (!enable || nrzi_mode || cmd_search) begin
      st   <= '0;
      seen <= 1'b0;
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (relock) begin
        seen <= 1'b1;
        prev <= 1'b0;
      end else if (wrap) begin
        seen <= 1'b0;
        if (seen) begin
          prev <= 1'b0;
        end else begin
          prev   <= 1'b1;
          st.one <= 1'b1;
          if (prev) begin
            st.two <= 1'b1;
            pend   <= 1'b1;
          end
        end
      end else if (win_edge) begin
        seen <= 1'b1;
      end
      if (searching) pend <= 1'b0;
      if (cmd_clr)   st   <= '0;
    end
  end

  assign miss_one   = st.one;
  assign miss_two   = st.two;
  assign search_req = pend;

endmodule

// File: rtl/fm_dpll_recover.sv
module fm_dpll_recover #(
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int SEARCH_AT   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic nrzi_mode,
  input  logic serial_in,
  input  logic cmd_search,
  input  logic cmd_clr_miss,
  output logic rclk,
  output logic tclk,
  output logic miss_one,
  output logic miss_two
);
  logic             edge_p;
  logic [CNT_W-1:0] cnt_q;
  logic             srch_q;
  logic             wrap;
  logic             win_edge;
  logic             relock;
  logic             search_req;

  fm_dpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (serial_in),
    .edge_p (edge_p)
  );

  fm_dpll_phase #(.CNT_W(CNT_W), .SEARCH_AT(SEARCH_AT)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .edge_p     (edge_p),
    .cmd_search (cmd_search),
    .search_req (search_req),
    .cnt        (cnt_q),
    .searching  (srch_q),
    .wrap       (wrap),
    .win_edge   (win_edge),
    .relock     (relock),
    .rclk       (rclk),
    .tclk       (tclk)
  );

  fm_dpll_miss u_miss (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .nrzi_mode  (nrzi_mode),
    .cmd_search (cmd_search),
    .cmd_clr    (cmd_clr_miss),
    .searching  (srch_q),
    .wrap       (wrap),
    .win_edge   (win_edge),
    .relock     (relock),
    .miss_one   (miss_one),
    .miss_two   (miss_two),
    .search_req (search_req)
  );

endmodule

// File: rtl/fm_dpll_chk.sv
module fm_dpll_chk #(
  parameter int CNT_W     = 5,
  parameter int SEARCH_AT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             nrzi_mode,
  input logic             cmd_search,
  input logic             cmd_clr_miss,
  input logic             rclk,
  input logic             tclk,
  input logic             miss_one,
  input logic             miss_two,
  input logic [CNT_W-1:0] cnt,
  input logic             searching
);
  localparam logic [CNT_W-1:0] LOCK_C = CNT_W'((1 << CNT_W) / 2 + 1);
  localparam logic [CNT_W-1:0] SRCH_C = CNT_W'(SEARCH_AT);
  localparam logic [CNT_W-1:0] TWO_C  = CNT_W'(2);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] dlt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_d <= '0;
    else        cnt_d <= cnt;
  end
  assign dlt = cnt - cnt_d;

  AST_SEARCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    searching |-> (!rclk && !tclk)); // R8

  AST_SEARCH_ENTRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(searching) && $past(enable) && !$past(cmd_search))
      |-> ($past(cnt) == SRCH_C && !$past(rclk) && !$past(tclk))); // R8

  AST_FLAGS_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || nrzi_mode || cmd_search) |=> (!miss_one && !miss_two)); // R10

  AST_TWO_WITH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_two |-> miss_one); // R7

  AST_TWO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_two && enable && !nrzi_mode && !cmd_clr_miss && !cmd_search)
      |=> miss_two); // R9

  AST_RELOCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(searching) |-> (cnt == LOCK_C)); // R11

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !searching && !cmd_search) |=> (searching || dlt <= TWO_C)); // R4

endmodule

bind fm_dpll_recover fm_dpll_chk #(.CNT_W(CNT_W), .SEARCH_AT(SEARCH_AT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .nrzi_mode    (nrzi_mode),
  .cmd_search   (cmd_search),
  .cmd_clr_miss (cmd_clr_miss),
  .rclk         (rclk),
  .tclk         (tclk),
  .miss_one     (miss_one),
  .miss_two     (miss_two),
  .cnt          (cnt_q),
  .searching    (srch_q)
);

// File: tb/sim_fm_dpll_recover.sv
module sim_fm_dpll_recover;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n, enable, nrzi_mode, serial_in, cmd_search, cmd_clr_miss;
  logic rclk, tclk, miss_one, miss_two;

  fm_dpll_recover u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .nrzi_mode    (nrzi_mode),
    .serial_in    (serial_in),
    .cmd_search   (cmd_search),
    .cmd_clr_miss (cmd_clr_miss),
    .rclk         (rclk),
    .tclk         (tclk),
    .miss_one     (miss_one),
    .miss_two     (miss_two)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  int  last_r = -1, last_t = -1, per_r = 0, hi_r = 0, diff_rt = 0;
  int  rr_n = 0, tr_n = 0, m1_at = -1, m2_at = -1;
  logic pr_r = 0, pr_t = 0, pr_m1 = 0, pr_m2 = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sampling cycle, observed at the falling edge
  task automatic step();
    @(negedge clk);
    if (rclk && !pr_r) begin
      rr_n++;
      if (last_r >= 0) per_r = cyc - last_r;
      diff_rt = cyc - last_t;
      last_r  = cyc;
    end
    if (!rclk && pr_r) hi_r = cyc - last_r;
    if (tclk && !pr_t) begin tr_n++; last_t = cyc; end
    if (miss_one && !pr_m1) m1_at = cyc;
    if (miss_two && !pr_m2) m2_at = cyc;
    pr_r = rclk; pr_t = tclk; pr_m1 = miss_one; pr_m2 = miss_two;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // send n cells of the given length; skip = cell index without boundary edge
  task automatic cells(input int n, input int len, input bit mid, input int skip);
    for (int c = 0; c < n; c++) begin
      for (int k = 0; k < len; k++) begin
        if (k == 0 && c != skip) serial_in = ~serial_in;
        if (mid && k == len / 2) serial_in = ~serial_in;
        step();
      end
    end
  endtask

  // one transition from search mode, then the rest of a 32-cycle cell
  task automatic relock(input string req);
    serial_in = ~serial_in;
    step(); step();
    chk({req, " rclk before 3rd edge"}, int'(rclk), 0);
    step();
    chk({req, " rclk at 3rd edge"}, int'(rclk), 1);
    steps(29);
  endtask

  task automatic t_reset();
    rst_n = 0; enable = 0; nrzi_mode = 0; serial_in = 0;
    cmd_search = 0; cmd_clr_miss = 0;
    steps(3);
    rst_n = 1;
    steps(4);
    chk("R1 rclk in reset/disabled", int'(rclk), 0);
    chk("R1 tclk in reset/disabled", int'(tclk), 0);
    chk("R1 flags in reset/disabled", int'({miss_two, miss_one}), 0);
    enable = 1;
    begin
      int r0 = rr_n, t0 = tr_n;
      steps(70);
      chk("R1 no clock before first edge", rr_n + tr_n - r0 - t0, 0);
      chk("R1 no flag while searching", int'({miss_two, miss_one}), 0);
    end
  endtask

  task automatic t_track();
    relock("R2");
    cells(4, 32, 0, -1);
    chk("R3 rclk period", per_r, 32);
    chk("R3 rclk high time", hi_r, 16);
    chk("R3 tclk leads rclk", diff_rt, 8);
    cells(6, 31, 0, -1);
    chk("R4 early edge period", per_r, 31);
    cells(6, 33, 0, -1);
    chk("R4 late edge period", per_r, 33);
    cells(5, 32, 1, -1);
    chk("R5 mid-cell edges ignored", per_r, 32);
    chk("R5 no flag from mid-cell edges", int'(miss_one), 0);
  endtask

  task automatic t_single_miss();
    cells(6, 32, 0, 2);
    chk("R6 miss_one set", int'(miss_one), 1);
    chk("R6 miss_two clear", int'(miss_two), 0);
    chk("R6 period unchanged", per_r, 32);
    cmd_clr_miss = 1; step(); cmd_clr_miss = 0;
    chk("R9 clear command", int'({miss_two, miss_one}), 0);
  endtask

  task automatic t_double_miss();
    int r0, t0;
    m1_at = -1; m2_at = -1;
    for (int i = 0; i < 200 && !miss_two; i++) step();
    chk("R7 miss_two after miss_one", m2_at - m1_at, 32);
    chk("R7 miss_one kept", int'(miss_one), 1);
    r0 = rr_n; t0 = tr_n;
    steps(150);
    chk("R8 no tclk pulse in search", tr_n - t0, 0);
    chk("R8 no rclk pulse in search", rr_n - r0, 0);
    chk("R9 miss_two sticky", int'(miss_two), 1);
    relock("R11");
    chk("R11 flags kept on relock", int'({miss_two, miss_one}), 3);
    cells(2, 32, 0, -1);
    chk("R11 period after relock", per_r, 32);
    cmd_clr_miss = 1; step(); cmd_clr_miss = 0;
    chk("R9 clear of both flags", int'({miss_two, miss_one}), 0);
  endtask

  task automatic t_commands();
    int r0;
    cells(4, 32, 0, 1);
    chk("R6 miss_one before search cmd", int'(miss_one), 1);
    cmd_search = 1; step(); cmd_search = 0;
    chk("R9 search cmd clears flag", int'(miss_one), 0);
    chk("R9 search cmd stops rclk", int'(rclk), 0);
    chk("R9 search cmd stops tclk", int'(tclk), 0);
    r0 = rr_n;
    steps(40);
    chk("R9 clocks idle after search cmd", rr_n - r0, 0);
    relock("R11");
    cells(4, 32, 0, 1);
    chk("R6 miss_one before disable", int'(miss_one), 1);
    enable = 0; step();
    chk("R9 disable clears flag", int'(miss_one), 0);
    chk("R1 disable stops rclk", int'(rclk), 0);
    steps(5);
    enable = 1;
  endtask

  task automatic t_nrzi();
    int r0;
    nrzi_mode = 1;
    relock("R10");
    cells(2, 32, 0, -1);
    m1_at = -1;
    r0 = rr_n;
    steps(160);
    chk("R10 flags held clear", int'({miss_two, miss_one}), 0);
    chk("R10 no flag rise", m1_at, -1);
    chk("R10 clocks keep running", int'(rr_n - r0 >= 4), 1);
    nrzi_mode = 0;
  endtask

  initial begin
    t_reset();
    t_track();
    t_single_miss();
    t_double_miss();
    t_commands();
    t_nrzi();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule